// File: doc/BRIEF.md
# DTMF Digit Qualifier with Guard Timing

This block sits between a tone detector and a serial output stage in a tone-dialling receiver. The tone detector supplies two 4-bit flag vectors, one for the four row (low-group) tones and one for the four column (high-group) tones. The qualifier checks that exactly one row and exactly one column are present and maps the pair to a 4-bit digit code. It then applies guard timing before it passes that code on.

A pair must be held without change for at least 40 ms before it is accepted, and acceptance must happen no later than 45 ms after the pair appeared. On acceptance the block updates its code output and raises a pulse for one clock cycle, which the downstream serializer consumes. The block then stays locked until the line has been free of any valid pair for at least 20 ms. Shorter gaps do not count as a pause, so one long key press gives exactly one digit.

All timing comes from a 1 ms tick that is divided down from the system clock. A synchronous active-low reset and a power-down input both return the block to its idle, armed state.

Top module: `dtmf_digit_qualifier`

## Requirements
- R1: Bit i of `row_tone` marks row i and bit j of `col_tone` marks column j. The rows are 697, 770, 852 and 941 Hz at bits 0 to 3, and the columns are 1209, 1336, 1477 and 1633 Hz at bits 0 to 3. The pair (i, j) yields these codes: keys 1 to 9 (i<3, j<3) give 3*i+j+1; (3,0) `*` gives 11; (3,1) `0` gives 10; (3,2) `#` gives 12; column 3 gives 13, 14, 15 and 0 for rows 0, 1, 2 and 3 (A, B, C, D).
- R2: Any input without exactly one `row_tone` bit and exactly one `col_tone` bit set counts as silence. It produces no acceptance and it restarts the stability count.
- R3: A valid pair is accepted only after it has stayed unchanged for at least ACCEPT_MS (40) ms. The `digit_valid` pulse comes no later than 45 ms after the pair appears.
- R4: A valid pair that lasts less than 20 ms is never accepted.
- R5: If the valid pair changes while it is being qualified, the count restarts from the new pair, and the code reported is the new pair's code.
- R6: `digit_valid` is high for exactly one cycle per acceptance. `digit_code` changes only on acceptance or on a clear, and it holds between those events.
- R7: After an acceptance, no further digit is accepted until silence has lasted at least PAUSE_MS (20) ms. A gap shorter than 20 ms does not re-arm the block, whether the tone that follows is the same or different.
- R8: The pause is recognised within 25 ms of silence. A valid pair that starts 24 ms after the previous tone ended is accepted again.
- R9: After reset, and after a cycle with `pwr_down` high, `digit_code` is 0 and `digit_valid` is 0. All timing restarts, so a tone that spans the clear needs a fresh 40 ms after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_down | input | 1 | Synchronous clear of all state while high |
| row_tone | input | 4 | Low-group tone-present flags, bit i = row i |
| col_tone | input | 4 | High-group tone-present flags, bit j = column j |
| digit_code | output | 4 | Code of the last accepted digit |
| digit_valid | output | 1 | One-cycle pulse on digit acceptance |

## Verification
If the qualification state machine gets a wrong state or count, the fault shows first in the `digit_valid` timing. The pulse either comes before 40 ms of stable input, or it is missing 45 ms after a clean pair. A broken pause tracker shows as a second pulse after a short break, or as no pulse 24 ms after silence, so the fault is visible within one key press. A wrong row or column decode shows as a wrong `digit_code` on the first acceptance of the affected key. That is why every one of the sixteen keys is driven at least once.

// File: rtl/dtmf_qual_pkg.sv
// Shared types and the key map of the digit qualifier.
// Assumes a 4-by-4 key matrix with one-hot row and column indices.
package dtmf_qual_pkg;

    localparam int unsigned GROUP_TONES = 4;
    localparam int unsigned IDX_W       = $clog2(GROUP_TONES);

    typedef logic [3:0]       digit_t;
    typedef logic [IDX_W-1:0] tone_idx_t;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_QUALIFY = 2'd1,
        ST_LOCKED  = 2'd2
    } guard_state_t;

    // Map a (row, column) index pair onto the output code order.
    function automatic digit_t pair_to_digit(tone_idx_t row, tone_idx_t col);
        digit_t code;
        if (col == tone_idx_t'(3)) begin
            case (row)
                2'd0:    code = 4'd13;
                2'd1:    code = 4'd14;
                2'd2:    code = 4'd15;
                default: code = 4'd0;
            endcase
        end else if (row == tone_idx_t'(3)) begin
            case (col)
                2'd0:    code = 4'd11;
                2'd1:    code = 4'd10;
                default: code = 4'd12;
            endcase
        end else begin
            code = (4'(row) * 4'd3) + 4'(col) + 4'd1;
        end
        return code;
    endfunction

endpackage

// File: rtl/dtmf_tick_gen.sv
// Millisecond tick generator.
// Produces a one-cycle tick every TICK_DIV clocks; clr restarts the period.
module dtmf_tick_gen #(
    parameter int unsigned TICK_DIV = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_cnt;

    // Wrap the divider at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            div_cnt <= '0;
        else if (div_cnt == LAST)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + 1'b1;
    end

    assign tick = (div_cnt == LAST);

endmodule

// File: rtl/dtmf_pair_decode.sv
// Tone-pair validator and key decoder (combinational).
// Assumes flag vectors are GROUP_TONES wide; anything but one-hot in both is invalid.
module dtmf_pair_decode
    import dtmf_qual_pkg::*;
(
    input  logic [GROUP_TONES-1:0] row_tone,
    input  logic [GROUP_TONES-1:0] col_tone,
    output logic                   pair_ok,
    output digit_t                 pair_code
);
    tone_idx_t row_idx;
    tone_idx_t col_idx;

    // Encode the index of the set bit in each group.
    always_comb begin
        row_idx = '0;
        col_idx = '0;
        for (int i = 0; i < GROUP_TONES; i++) begin
            if (row_tone[i]) row_idx = tone_idx_t'(i);
            if (col_tone[i]) col_idx = tone_idx_t'(i);
        end
    end

    // Valid only with exactly one tone per group.
    assign pair_ok   = ($countones(row_tone) == 1) && ($countones(col_tone) == 1);
    assign pair_code = pair_to_digit(row_idx, col_idx);

endmodule

// File: rtl/dtmf_guard_fsm.sv
// Guard-time state machine of the qualifier.
// Accepts a pair after ACCEPT_MS+1 ticks of unchanged input and re-arms after
// PAUSE_MS+1 ticks of silence; counting whole ticks keeps both bounds conservative.
module dtmf_guard_fsm
    import dtmf_qual_pkg::*;
#(
    parameter int unsigned ACCEPT_MS = 40,
    parameter int unsigned PAUSE_MS  = 20
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  logic   tick,
    input  logic   pair_ok,
    input  digit_t pair_code,
    output digit_t digit_code,
    output logic   digit_valid
);
    localparam int unsigned CNT_MAX = (ACCEPT_MS > PAUSE_MS) ? ACCEPT_MS : PAUSE_MS;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] ACC_END   = CNT_W'(ACCEPT_MS);
    localparam logic [CNT_W-1:0] PAUSE_END = CNT_W'(PAUSE_MS);

    guard_state_t     state;
    digit_t           cand;
    logic [CNT_W-1:0] ms_cnt;

    // Qualify, accept, and hold off until a pause.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state       <= ST_ARMED;
            cand        <= '0;
            ms_cnt      <= '0;
            digit_code  <= '0;
            digit_valid <= 1'b0;
        end else begin
            digit_valid <= 1'b0;
            case (state)
                ST_ARMED: begin
                    if (pair_ok) begin
                        state  <= ST_QUALIFY;
                        cand   <= pair_code;
                        ms_cnt <= '0;
                    end
                end
                ST_QUALIFY: begin
                    if (!pair_ok) begin
                        state <= ST_ARMED;
                    end else if (pair_code != cand) begin
                        cand   <= pair_code;
                        ms_cnt <= '0;
                    end else if (tick) begin
                        if (ms_cnt == ACC_END) begin
                            state       <= ST_LOCKED;
                            digit_code  <= cand;
                            digit_valid <= 1'b1;
                            ms_cnt      <= '0;
                        end else begin
                            ms_cnt <= ms_cnt + 1'b1;
                        end
                    end
                end
                ST_LOCKED: begin
                    if (pair_ok)
                        ms_cnt <= '0;
                    else if (tick) begin
                        if (ms_cnt == PAUSE_END)
                            state <= ST_ARMED;
                        else
                            ms_cnt <= ms_cnt + 1'b1;
                    end
                end
                default: state <= ST_ARMED;
            endcase
        end
    end

endmodule

// File: rtl/dtmf_qual_checker.sv
// Property checker for the digit qualifier, bound to the top module.
// Tracks stable-pair and silence run lengths in clock cycles.
module dtmf_qual_checker
    import dtmf_qual_pkg::*;
#(
    parameter int unsigned TICK_DIV  = 250000,
    parameter int unsigned ACCEPT_MS = 40,
    parameter int unsigned PAUSE_MS  = 20
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pwr_down,
    input logic [GROUP_TONES-1:0] row_tone,
    input logic [GROUP_TONES-1:0] col_tone,
    input digit_t                 digit_code,
    input logic                   digit_valid
);
    localparam int unsigned STAB_LIM  = ACCEPT_MS * TICK_DIV;
    localparam int unsigned QUIET_LIM = PAUSE_MS * TICK_DIV;

    int unsigned stab_run;
    int unsigned quiet_run;
    logic        gap_ok;
    logic        prev_ok;
    logic [GROUP_TONES-1:0] prev_row, prev_col;
    logic        cur_ok;

    assign cur_ok = ($countones(row_tone) == 1) && ($countones(col_tone) == 1);

    // Count consecutive cycles of one unchanged pair and of silence.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down) begin
            stab_run  <= 0;
            quiet_run <= 0;
            gap_ok    <= 1'b1;
            prev_ok   <= 1'b0;
            prev_row  <= '0;
            prev_col  <= '0;
        end else begin
            prev_ok  <= cur_ok;
            prev_row <= row_tone;
            prev_col <= col_tone;
            if (cur_ok && prev_ok && row_tone == prev_row && col_tone == prev_col)
                stab_run <= (stab_run == 32'hFFFF_FFFF) ? stab_run : stab_run + 1;
            else
                stab_run <= cur_ok ? 1 : 0;
            if (cur_ok)
                quiet_run <= 0;
            else if (quiet_run != 32'hFFFF_FFFF)
                quiet_run <= quiet_run + 1;
            if (digit_valid)
                gap_ok <= 1'b0;
            else if (!cur_ok && (quiet_run + 1 >= QUIET_LIM))
                gap_ok <= 1'b1;
        end
    end

    // R6: acceptance pulse lasts one cycle.
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        digit_valid |=> !digit_valid);

    // R6: code holds between acceptances unless cleared.
    a_r6_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!digit_valid && !$past(pwr_down)) |-> $stable(digit_code));

    // R2: acceptance only follows a valid one-hot pair.
    a_r2_valid_pair: assert property (@(posedge clk) disable iff (!rst_n)
        digit_valid |-> ($countones($past(row_tone)) == 1 && $countones($past(col_tone)) == 1));

    // R1: reported code matches the pair held at acceptance.
    a_r1_code_map: assert property (@(posedge clk) disable iff (!rst_n)
        digit_valid |-> digit_code == pair_to_digit(
            tone_idx_t'($clog2($past(row_tone))), tone_idx_t'($clog2($past(col_tone)))));

    // R3: acceptance only after the qualification time of stable input.
    a_r3_stable_time: assert property (@(posedge clk) disable iff (!rst_n)
        digit_valid |-> stab_run >= STAB_LIM);

    // R7: no second acceptance without an intervening pause.
    a_r7_pause_first: assert property (@(posedge clk) disable iff (!rst_n)
        digit_valid |-> gap_ok);

    // R9: clear suppresses the pulse and zeroes the code.
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwr_down) |-> (!digit_valid && digit_code == 4'd0));

endmodule

bind dtmf_digit_qualifier dtmf_qual_checker #(
    .TICK_DIV  (TICK_DIV),
    .ACCEPT_MS (ACCEPT_MS),
    .PAUSE_MS  (PAUSE_MS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_down    (pwr_down),
    .row_tone    (row_tone),
    .col_tone    (col_tone),
    .digit_code  (digit_code),
    .digit_valid (digit_valid)
);

// File: rtl/dtmf_digit_qualifier.sv
// Top of the digit qualifier: tick divider, pair decoder, guard FSM.
// Assumes flags are already synchronous to clk; TICK_DIV clocks make 1 ms.
module dtmf_digit_qualifier
    import dtmf_qual_pkg::*;
#(
    parameter int unsigned TICK_DIV  = 250000,
    parameter int unsigned ACCEPT_MS = 40,
    parameter int unsigned PAUSE_MS  = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwr_down,
    input  logic [GROUP_TONES-1:0] row_tone,
    input  logic [GROUP_TONES-1:0] col_tone,
    output logic [3:0]             digit_code,
    output logic                   digit_valid
);
    logic   tick;
    logic   pair_ok;
    digit_t pair_code;

    dtmf_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pwr_down),
        .tick  (tick)
    );

    dtmf_pair_decode u_dec (
        .row_tone  (row_tone),
        .col_tone  (col_tone),
        .pair_ok   (pair_ok),
        .pair_code (pair_code)
    );

    dtmf_guard_fsm #(
        .ACCEPT_MS (ACCEPT_MS),
        .PAUSE_MS  (PAUSE_MS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (pwr_down),
        .tick        (tick),
        .pair_ok     (pair_ok),
        .pair_code   (pair_code),
        .digit_code  (digit_code),
        .digit_valid (digit_valid)
    );

endmodule

// File: tb/sim_dtmf_digit_qualifier.sv
// Bench for the digit qualifier: directed corners plus seeded random key presses.
module sim_dtmf_digit_qualifier;
    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_down = 1'b0;
    logic [3:0] row_tone = '0;
    logic [3:0] col_tone = '0;
    logic [3:0] digit_code;
    logic       digit_valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pulses = 0;
    int last_pulse_cyc = 0;
    bit wide_pulse = 0;
    bit prev_valid = 0;
    bit armed = 1;

    always #2 clk = ~clk;

    dtmf_digit_qualifier #(.TICK_DIV(DIV), .ACCEPT_MS(40), .PAUSE_MS(20)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .row_tone(row_tone), .col_tone(col_tone),
        .digit_code(digit_code), .digit_valid(digit_valid)
    );

    // Observe outputs away from the active edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (digit_valid) begin
            pulses <= pulses + 1;
            last_pulse_cyc <= cyc;
        end
        if (digit_valid && prev_valid) wide_pulse <= 1;
        prev_valid <= digit_valid;
    end

    function automatic int key_code(int r, int c);
        string keys = "123A456B789C*0#D";
        byte k = keys[r*4+c];
        if (k >= "1" && k <= "9") return k - "0";
        if (k == "0") return 10;
        if (k == "*") return 11;
        if (k == "#") return 12;
        if (k == "A") return 13;
        if (k == "B") return 14;
        if (k == "C") return 15;
        return 0;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_ms(int n);
        repeat (n * DIV) @(negedge clk);
    endtask

    task automatic set_pair(int r, int c);
        row_tone = 4'(1 << r);
        col_tone = 4'(1 << c);
    endtask

    task automatic set_quiet();
        row_tone = '0;
        col_tone = '0;
    endtask

    task automatic set_bad(int kind);
        case (kind % 3)
            0: begin row_tone = 4'b0011; col_tone = 4'b0100; end
            1: begin row_tone = 4'b0010; col_tone = 4'b0000; end
            default: begin row_tone = 4'b1000; col_tone = 4'b0110; end
        endcase
    endtask

    // One press of length len ms, then a gap; checks count, code and latency.
    task automatic burst(int r, int c, int len, int gap, bit gap_bad, bit exp_acc, string req);
        int p0 = pulses;
        int s;
        set_pair(r, c);
        s = cyc;
        wait_ms(len);
        if (gap_bad) set_bad(r + c); else set_quiet();
        wait_ms(gap);
        chk((pulses - p0) == (exp_acc ? 1 : 0), req, "accept count", pulses - p0, exp_acc ? 1 : 0);
        if (exp_acc) begin
            chk(int'(digit_code) == key_code(r, c), "R1/R6", "held code", digit_code, key_code(r, c));
            chk((last_pulse_cyc - s) >= 40*DIV - 2 && (last_pulse_cyc - s) <= 45*DIV,
                "R3", "latency cycles", last_pulse_cyc - s, 40*DIV);
        end
    endtask

    initial begin
        int p0;
        // R9: reset state.
        repeat (3) @(negedge clk);
        chk(digit_valid == 0, "R9", "valid in reset", digit_valid, 0);
        chk(digit_code == 0, "R9", "code in reset", digit_code, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R3, R8: every key, re-armed after a 24 ms gap.
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                burst(r, c, 44, 24, 0, 1, "R8");

        // R4: short presses are not accepted.
        burst(2, 1, 18, 24, 0, 0, "R4");
        burst(0, 3, 35, 24, 0, 0, "R3 35ms");

        // R2: invalid patterns never qualify and break qualification.
        p0 = pulses;
        set_bad(0); wait_ms(50);
        set_bad(2); wait_ms(50);
        set_quiet(); wait_ms(24);
        chk(pulses == p0, "R2", "invalid accepted", pulses - p0, 0);
        p0 = pulses;
        set_pair(1, 2); wait_ms(30);
        set_bad(1); wait_ms(1);
        set_pair(1, 2); wait_ms(30);
        set_quiet(); wait_ms(24);
        chk(pulses == p0, "R2", "restart by invalid", pulses - p0, 0);

        // R5: change during qualification restarts the count.
        set_pair(0, 0); wait_ms(30);
        burst(3, 2, 44, 24, 0, 1, "R5");

        // R7: short break does not re-arm.
        burst(1, 1, 44, 12, 0, 1, "R7 first");
        burst(1, 1, 50, 24, 0, 0, "R7 same after break");
        burst(0, 0, 44, 10, 0, 1, "R7 first b");
        burst(2, 2, 50, 24, 0, 0, "R7 other after break");
        // R7: an invalid pattern counts as silence for the pause.
        burst(0, 1, 44, 24, 1, 1, "R7 bad gap");
        burst(0, 2, 44, 24, 0, 1, "R8 after bad gap");

        // R9: power-down clears the code and restarts timing.
        p0 = pulses;
        set_pair(0, 1); wait_ms(30);
        pwr_down = 1'b1; @(negedge clk);
        pwr_down = 1'b0; @(negedge clk);
        chk(digit_code == 0, "R9", "code after clear", digit_code, 0);
        wait_ms(30);
        set_quiet(); wait_ms(25);
        chk(pulses == p0, "R9", "accept across clear", pulses - p0, 0);

        // Random presses against a bench model of arming.
        armed = 1;
        void'($urandom(32'd2024));
        for (int n = 0; n < 60; n++) begin
            int r = $urandom % 4;
            int c = $urandom % 4;
            bit longb = ($urandom % 3) != 0;
            bit gl = $urandom % 2;
            bit bad = ($urandom % 4) == 0;
            int len = longb ? 44 + $urandom % 6 : 3 + $urandom % 13;
            int gap = gl ? 23 + $urandom % 7 : 2 + $urandom % 13;
            bit exp_acc = armed && longb;
            bit held = exp_acc || !armed;
            burst(r, c, len, gap, bad, exp_acc, "R7 random");
            if (held) armed = gl;
        end

        chk(!wide_pulse, "R6", "pulse wider than one cycle", wide_pulse, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule